// File: doc/BRIEF.md
# Console Memory Map Decoder

This block sits between an 8-bit CPU and the devices of a small handheld console. Each 16-bit CPU address is sorted into one device select code, and where the device needs it, a local offset within that device. The block also returns read data from whichever device the address selects. The devices themselves are outside the block. The decoder gets their read data through one input per device and drives a read or write strobe towards them.

A few pieces of state live inside the decoder:
- a flag that overlays a 256-byte start-up ROM on the lowest addresses until software turns it off;
- the selector for the switchable 4 KiB work RAM window;
- the interrupt enable byte;
- a 127-byte fast RAM near the top of the map;
- a one-byte serial latch. Writing this latch out produces a pulse on a character output, which a debug harness can watch.

Some ranges always read as zero and ignore writes: the audio registers, the serial port, the unusable hole above sprite memory, and every undecoded I/O slot. The work RAM range also has a mirror region above it that reaches the same storage.

Top module: `mmap_decoder`

## Requirements
- R1: `dev_sel` codes are: 0 none, 1 start-up ROM, 2 cartridge ROM, 3 video RAM, 4 cartridge RAM, 5 work RAM, 6 sprite memory, 7 joypad, 8 serial, 9 timer, 10 interrupt flags, 11 audio, 12 video registers, 13 fast RAM, 14 interrupt enable, 15 decoder control. Codes 1–7, 9, 10 and 12 are external. `dev_rd`/`dev_wr` equal `cpu_rd`/`cpu_wr` while an external code is selected, and are 0 otherwise. Codes 0, 8, 11, 14 and 15 give offset 0.
- R2: After reset the start-up overlay is on. While it is on, a read (`cpu_wr` low) of 0x0000–0x00FF selects code 1 with offset equal to the address and returns `boot_rdata`. A write to that range still selects the cartridge.
- R3: A write of a nonzero byte to 0xFF50 turns the overlay off until the next reset. A write of zero does nothing.
- R4: 0x0000–0x7FFF (overlay aside) selects code 2 with offset equal to the address. 0x8000–0x9FFF selects code 3 with offset address−0x8000. 0xA000–0xBFFF selects code 4 with offset address−0xA000. Codes 2 and 4 return `cart_rdata`, and code 3 returns `vram_rdata`.
- R5: 0xC000–0xCFFF selects code 5 with offset address−0xC000. 0xD000–0xDFFF selects code 5 with offset (address−0xD000)+0x1000×bank, where bank is the effective bank. Code 5 returns `wram_rdata`.
- R6: 0xE000–0xFDFF behaves exactly like the address 0x2000 lower.
- R7: A write to 0xFF70 stores bits 2:0 as the bank. A stored 0 gives effective bank 1. Reading 0xFF70 returns the stored 3 bits with the upper bits zero, and the stored value is 0 after reset. Reading 0xFF50 returns 0.
- R8: 0xFE00–0xFE9F selects code 6 with offset address−0xFE00 and returns `oam_rdata`. 0xFEA0–0xFEFF selects code 0 and reads 0.
- R9: Several I/O addresses select code 7, 9, 10 or 12 with offset equal to the low address byte, and return `joy_rdata`, `timer_rdata`, `iflag_rdata` or `vreg_rdata`:
  - 0xFF00 selects code 7;
  - 0xFF04–0xFF07 select code 9;
  - 0xFF0F selects code 10;
  - 0xFF40–0xFF4B and 0xFF68–0xFF6B select code 12.
- R10: Several addresses read 0 and never raise a strobe:
  - 0xFF01–0xFF02 (code 8);
  - 0xFF10–0xFF3F (code 11);
  - every other undecoded 0xFFxx address (code 0).
- R11: 0xFF80–0xFFFE is a 127-byte fast RAM selected as code 13, with offset address−0xFF80. It is cleared by reset, written on `cpu_wr`, and read back combinationally.
- R12: 0xFFFF selects code 14. It is a byte register that resets to 0 and reads back the last byte written.
- R13: A write to 0xFF01 loads the serial latch. A write to 0xFF02 raises `dbg_valid` for the next single cycle. In that same cycle `dbg_char` shows the latch value from before the write. `dbg_char` holds the last emitted byte and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data for the CPU (combinational) |
| dev_sel | output | 4 | Selected device code |
| dev_offset | output | 16 | Local offset within the device |
| dev_rd | output | 1 | Read strobe to the external device |
| dev_wr | output | 1 | Write strobe to the external device |
| boot_rdata | input | 8 | Start-up ROM read data |
| cart_rdata | input | 8 | Cartridge read data |
| vram_rdata | input | 8 | Video RAM read data |
| wram_rdata | input | 8 | Work RAM read data |
| oam_rdata | input | 8 | Sprite memory read data |
| joy_rdata | input | 8 | Joypad read data |
| timer_rdata | input | 8 | Timer read data |
| iflag_rdata | input | 8 | Interrupt flag read data |
| vreg_rdata | input | 8 | Video register read data |
| dbg_valid | output | 1 | One-cycle character pulse |
| dbg_char | output | 8 | Emitted character |

## Verification
The hardest states to reach are the ones that depend on earlier writes rather than on the address alone. One is the overlay after it has been switched off by a nonzero write, which a zero write must not imitate. Another is an echo access through a bank register that holds zero or the top bank. A third is the character pulse that follows a latch-then-emit pair of writes. The stimulus steps through these sequences directly, using a reset in the middle of the run to bring the overlay back. It then issues a long random run biased towards the top page and the work RAM range, so that register writes and reads interleave in orders that were not planned.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

   typedef enum logic [3:0] {
      DEV_NONE = 4'd0,
      DEV_BOOT = 4'd1,
      DEV_CROM = 4'd2,
      DEV_VRAM = 4'd3,
      DEV_CRAM = 4'd4,
      DEV_WRAM = 4'd5,
      DEV_OAM  = 4'd6,
      DEV_JOY  = 4'd7,
      DEV_SER  = 4'd8,
      DEV_TMR  = 4'd9,
      DEV_IFLG = 4'd10,
      DEV_AUD  = 4'd11,
      DEV_VREG = 4'd12,
      DEV_HRAM = 4'd13,
      DEV_IE   = 4'd14,
      DEV_CTRL = 4'd15
   } dev_e;

   // true for devices that live outside the decoder and receive strobes
   function automatic logic is_external(dev_e d);
      case (d)
         DEV_BOOT, DEV_CROM, DEV_VRAM, DEV_CRAM, DEV_WRAM,
         DEV_OAM, DEV_JOY, DEV_TMR, DEV_IFLG, DEV_VREG: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/mmap_region_decode.sv
module mmap_region_decode
   import mmap_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int OFF_W  = 16
) (
   input  logic [15:0]       addr,
   input  logic              is_wr,
   input  logic              boot_en,
   input  logic [BANK_W-1:0] eff_bank,
   output dev_e              sel,
   output logic [OFF_W-1:0]  offset
);

   if (BANK_W + 12 > OFF_W) begin : g_bad_off
      $error("offset too narrow for banked work RAM");
   end

   logic [7:0] lo;
   assign lo = addr[7:0];

   always_comb begin
      sel    = DEV_NONE;
      offset = '0;
      if (!addr[15]) begin
         // overlay only hides reads; writes reach the cartridge controller
         sel    = (boot_en && !is_wr && addr[14:8] == 7'd0) ? DEV_BOOT : DEV_CROM;
         offset = OFF_W'(addr);
      end else if (addr[15:13] == 3'b100) begin
         sel    = DEV_VRAM;
         offset = OFF_W'(addr[12:0]);
      end else if (addr[15:13] == 3'b101) begin
         sel    = DEV_CRAM;
         offset = OFF_W'(addr[12:0]);
      end else if (addr < 16'hFE00) begin
         // bit 13 separates the echo, bit 12 picks fixed or switched window
         sel          = DEV_WRAM;
         offset[11:0] = addr[11:0];
         if (addr[12]) offset[12 +: BANK_W] = eff_bank;
      end else if (addr < 16'hFEA0) begin
         sel    = DEV_OAM;
         offset = OFF_W'(lo);
      end else if (addr[15:8] == 8'hFE) begin
         sel = DEV_NONE;
      end else if (lo == 8'h00) begin
         sel    = DEV_JOY;
         offset = OFF_W'(lo);
      end else if (lo == 8'h01 || lo == 8'h02) begin
         sel = DEV_SER;
      end else if (lo inside {[8'h04:8'h07]}) begin
         sel    = DEV_TMR;
         offset = OFF_W'(lo);
      end else if (lo == 8'h0F) begin
         sel    = DEV_IFLG;
         offset = OFF_W'(lo);
      end else if (lo inside {[8'h10:8'h3F]}) begin
         sel = DEV_AUD;
      end else if (lo inside {[8'h40:8'h4B], [8'h68:8'h6B]}) begin
         sel    = DEV_VREG;
         offset = OFF_W'(lo);
      end else if (lo == 8'h50 || lo == 8'h70) begin
         sel = DEV_CTRL;
      end else if (lo == 8'hFF) begin
         sel = DEV_IE;
      end else if (lo[7]) begin
         sel    = DEV_HRAM;
         offset = OFF_W'(lo[6:0]);
      end
   end

endmodule

// File: rtl/mmap_wram_bank.sv
module mmap_wram_bank #(
   parameter int BANK_W      = 3,
   parameter bit ZERO_IS_ONE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BANK_W-1:0] wdata,
   output logic [BANK_W-1:0] bank_q,
   output logic [BANK_W-1:0] eff_bank
);

   if (BANK_W < 1 || BANK_W > 4) begin : g_bad_bank
      $error("work RAM bank width out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bank_q <= '0;
      else if (we) bank_q <= wdata;
   end

   if (ZERO_IS_ONE) begin : g_zero_maps_one
      assign eff_bank = (bank_q == '0) ? BANK_W'(1) : bank_q;
   end else begin : g_zero_literal
      assign eff_bank = bank_q;
   end

   // R7
   bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we) |-> bank_q == $past(wdata) || $past(!rst_n));

endmodule

// File: rtl/mmap_hram.sv
module mmap_hram #(
   parameter int DEPTH = 127,
   parameter int AW    = 7,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   if (DEPTH < 1 || DEPTH > (1 << AW)) begin : g_bad_depth
      $error("fast RAM depth does not fit its address");
   end

   logic [DW-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      mem[i] <= '0;
         else if (we && addr == AW'(i))   mem[i] <= wdata;
      end
   end

   assign rdata = (int'(addr) < DEPTH) ? mem[addr] : '0;

   // R11
   hram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(we) && addr == $past(addr)) |-> $stable(rdata));

endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
   import mmap_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OFF_W      = 16,
   parameter int WBANK_W    = 3,
   parameter int HRAM_DEPTH = 127,
   parameter bit BANK0_AS_1 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [3:0]        dev_sel,
   output logic [OFF_W-1:0]  dev_offset,
   output logic              dev_rd,
   output logic              dev_wr,
   input  logic [DATA_W-1:0] boot_rdata,
   input  logic [DATA_W-1:0] cart_rdata,
   input  logic [DATA_W-1:0] vram_rdata,
   input  logic [DATA_W-1:0] wram_rdata,
   input  logic [DATA_W-1:0] oam_rdata,
   input  logic [DATA_W-1:0] joy_rdata,
   input  logic [DATA_W-1:0] timer_rdata,
   input  logic [DATA_W-1:0] iflag_rdata,
   input  logic [DATA_W-1:0] vreg_rdata,
   output logic              dbg_valid,
   output logic [DATA_W-1:0] dbg_char
);

   localparam int HRAM_AW = $clog2(HRAM_DEPTH);

   if (DATA_W != 8) begin : g_bad_dw
      $error("decoder data path must be one byte");
   end
   if (HRAM_DEPTH > 127) begin : g_bad_hram
      $error("fast RAM window holds at most 127 bytes");
   end

   dev_e              sel;
   logic [OFF_W-1:0]  off;
   logic              boot_en;
   logic [WBANK_W-1:0] bank_q, eff_bank;
   logic [DATA_W-1:0] ie_q, ser_latch, hram_rd;
   logic [7:0]        lo;
   logic              ext, ctrl_wr, ser_wr;

   assign lo = cpu_addr[7:0];

   mmap_region_decode #(.BANK_W(WBANK_W), .OFF_W(OFF_W)) i_decode (
      .addr     (cpu_addr),
      .is_wr    (cpu_wr),
      .boot_en  (boot_en),
      .eff_bank (eff_bank),
      .sel      (sel),
      .offset   (off)
   );

   assign ctrl_wr = cpu_wr && sel == DEV_CTRL;
   assign ser_wr  = cpu_wr && sel == DEV_SER;

   mmap_wram_bank #(.BANK_W(WBANK_W), .ZERO_IS_ONE(BANK0_AS_1)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ctrl_wr && lo == 8'h70),
      .wdata    (cpu_wdata[WBANK_W-1:0]),
      .bank_q   (bank_q),
      .eff_bank (eff_bank)
   );

   mmap_hram #(.DEPTH(HRAM_DEPTH), .AW(HRAM_AW), .DW(DATA_W)) i_hram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cpu_wr && sel == DEV_HRAM),
      .addr  (cpu_addr[HRAM_AW-1:0]),
      .wdata (cpu_wdata),
      .rdata (hram_rd)
   );

   assign ext        = is_external(sel);
   assign dev_sel    = sel;
   assign dev_offset = off;
   assign dev_rd     = cpu_rd && ext;
   assign dev_wr     = cpu_wr && ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_en   <= 1'b1;
         ie_q      <= '0;
         ser_latch <= '0;
         dbg_valid <= 1'b0;
         dbg_char  <= '0;
      end else begin
         if (ctrl_wr && lo == 8'h50 && cpu_wdata != '0) boot_en <= 1'b0;
         if (cpu_wr && sel == DEV_IE) ie_q <= cpu_wdata;
         if (ser_wr && !lo[1]) ser_latch <= cpu_wdata;
         dbg_valid <= ser_wr && lo[1];
         if (ser_wr && lo[1]) dbg_char <= ser_latch;
      end
   end

   always_comb begin
      case (sel)
         DEV_BOOT:           cpu_rdata = boot_rdata;
         DEV_CROM, DEV_CRAM: cpu_rdata = cart_rdata;
         DEV_VRAM:           cpu_rdata = vram_rdata;
         DEV_WRAM:           cpu_rdata = wram_rdata;
         DEV_OAM:            cpu_rdata = oam_rdata;
         DEV_JOY:            cpu_rdata = joy_rdata;
         DEV_TMR:            cpu_rdata = timer_rdata;
         DEV_IFLG:           cpu_rdata = iflag_rdata;
         DEV_VREG:           cpu_rdata = vreg_rdata;
         DEV_HRAM:           cpu_rdata = hram_rd;
         DEV_IE:             cpu_rdata = ie_q;
         DEV_CTRL:           cpu_rdata = (lo == 8'h70) ? DATA_W'(bank_q) : '0;
         default:            cpu_rdata = '0;
      endcase
   end

   // R3
   boot_off_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(boot_en) |-> $past(cpu_wr && cpu_addr == 16'hFF50 && cpu_wdata != '0));

   // R3
   boot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_en |=> !boot_en);

   // R13
   dbg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_valid |-> $past(cpu_wr && cpu_addr == 16'hFF02));

   // R1
   strobe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_wr |-> cpu_wr && (cpu_addr < 16'hFEA0 || cpu_addr[15:8] == 8'hFF));

   // R10
   quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == DEV_AUD || sel == DEV_SER || sel == DEV_NONE) |-> cpu_rdata == '0);

   if (BANK0_AS_1) begin : g_bank_chk
      // R5
      switched_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel == DEV_WRAM && cpu_addr[12]) |-> off[12 +: WBANK_W] != '0);
   end

endmodule

// File: tb/test_mmap_decoder.sv
module test_mmap_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        rd = 1'b0, wr = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [3:0]  sel;
   logic [15:0] off;
   logic        drd, dwr, dbgv;
   logic [7:0]  dbgc;

   int checks = 0;
   int errors = 0;

   // model state
   bit        m_boot;
   int        m_bank;
   int        m_ie;
   int        m_hram [127];
   int        m_latch;
   bit        m_dbgv;
   int        m_dbgc;

   always #10 clk = ~clk;

   mmap_decoder i_mmap_decoder (
      .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_rd(rd), .cpu_wr(wr),
      .cpu_wdata(wdata), .cpu_rdata(rdata), .dev_sel(sel), .dev_offset(off),
      .dev_rd(drd), .dev_wr(dwr),
      .boot_rdata(8'hA1), .cart_rdata(8'hA2), .vram_rdata(8'hA3),
      .wram_rdata(8'hA4), .oam_rdata(8'hA5), .joy_rdata(8'hA6),
      .timer_rdata(8'hA7), .iflag_rdata(8'hA8), .vreg_rdata(8'hA9),
      .dbg_valid(dbgv), .dbg_char(dbgc)
   );

   function automatic int m_sel(int a, bit w);
      int l = a & 'hFF;
      if (a < 'h100 && m_boot && !w) return 1;
      if (a < 'h8000) return 2;
      if (a < 'hA000) return 3;
      if (a < 'hC000) return 4;
      if (a < 'hFE00) return 5;
      if (a < 'hFEA0) return 6;
      if (a < 'hFF00) return 0;
      if (l == 0) return 7;
      if (l == 1 || l == 2) return 8;
      if (l >= 4 && l <= 7) return 9;
      if (l == 'h0F) return 10;
      if (l >= 'h10 && l <= 'h3F) return 11;
      if ((l >= 'h40 && l <= 'h4B) || (l >= 'h68 && l <= 'h6B)) return 12;
      if (l == 'h50 || l == 'h70) return 15;
      if (l == 'hFF) return 14;
      if (l >= 'h80) return 13;
      return 0;
   endfunction

   function automatic int m_off(int a, int s);
      int b, eff;
      eff = (m_bank == 0) ? 1 : m_bank;
      case (s)
         1, 2: return a;
         3: return a - 'h8000;
         4: return a - 'hA000;
         5: begin
            b = ((a >= 'hE000) ? a - 'h2000 : a) - 'hC000;
            return (b < 'h1000) ? b : (b - 'h1000) + 'h1000 * eff;
         end
         6: return a - 'hFE00;
         7, 9, 10, 12: return a & 'hFF;
         13: return a - 'hFF80;
         default: return 0;
      endcase
   endfunction

   function automatic int m_rdata(int a, int s);
      case (s)
         1: return 'hA1;
         2, 4: return 'hA2;
         3: return 'hA3;
         5: return 'hA4;
         6: return 'hA5;
         7: return 'hA6;
         9: return 'hA7;
         10: return 'hA8;
         12: return 'hA9;
         13: return m_hram[a - 'hFF80];
         14: return m_ie;
         15: return ((a & 'hFF) == 'h70) ? m_bank : 0;
         default: return 0;
      endcase
   endfunction

   function automatic bit m_ext(int s);
      return (s >= 1 && s <= 7) || s == 9 || s == 10 || s == 12;
   endfunction

   function automatic string tag_of(int a, int s);
      case (s)
         1: return "R2 R3";
         2: return (a < 'h100) ? "R3 R4" : "R4";
         3, 4: return "R4";
         5: return (a >= 'hE000) ? "R6" : "R5";
         6: return "R8";
         7, 9, 10, 12: return "R9";
         13: return "R11";
         14: return "R12";
         15: return "R7";
         default: return (a >= 'hFEA0 && a < 'hFF00) ? "R8" : "R10";
      endcase
   endfunction

   task automatic chk(int act, int exp, string tag, string what, int a);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, what, a[15:0], act, exp);
      end
   endtask

   task automatic model_reset();
      m_boot = 1; m_bank = 0; m_ie = 0; m_latch = 0; m_dbgv = 0; m_dbgc = 0;
      foreach (m_hram[i]) m_hram[i] = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; rd = 0; wr = 0; addr = '0; wdata = '0;
      repeat (3) @(posedge clk);
      model_reset();
      @(negedge clk);
      rst_n = 1;
      chk(int'(dbgv), 0, "R13", "dbg_valid after reset", 0);
      chk(int'(dbgc), 0, "R13", "dbg_char after reset", 0);
   endtask

   task automatic cycle(int a, bit r, bit w, int d);
      int s;
      string t;
      @(negedge clk);
      addr = a[15:0]; rd = r; wr = w; wdata = d[7:0];
      #2;
      s = m_sel(a, w);
      t = tag_of(a, s);
      chk(int'(sel), s, t, "dev_sel", a);
      chk(int'(off), m_off(a, s), t, "dev_offset", a);
      if (r) chk(int'(rdata), m_rdata(a, s), t, "cpu_rdata", a);
      chk(int'(drd), int'(r && m_ext(s)), "R1", "dev_rd", a);
      chk(int'(dwr), int'(w && m_ext(s)), "R1", "dev_wr", a);
      @(posedge clk);
      m_dbgv = 0;
      if (w) begin
         if (a == 'hFF50 && (d & 'hFF) != 0) m_boot = 0;
         if (a == 'hFF70) m_bank = d & 7;
         if (a == 'hFFFF) m_ie = d & 'hFF;
         if (a >= 'hFF80 && a <= 'hFFFE) m_hram[a - 'hFF80] = d & 'hFF;
         if (a == 'hFF02) begin m_dbgv = 1; m_dbgc = m_latch; end
         if (a == 'hFF01) m_latch = d & 'hFF;
      end
      #2;
      chk(int'(dbgv), int'(m_dbgv), "R13", "dbg_valid", a);
      chk(int'(dbgc), m_dbgc, "R13", "dbg_char", a);
   endtask

   initial begin : watchdog
      #(20 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      int edges [] = '{'h0000, 'h00FF, 'h0100, 'h7FFF, 'h8000, 'h9FFF, 'hA000,
         'hBFFF, 'hC000, 'hCFFF, 'hD000, 'hDFFF, 'hE000, 'hEFFF, 'hF000,
         'hFDFF, 'hFE00, 'hFE9F, 'hFEA0, 'hFEFF, 'hFF00, 'hFF01, 'hFF02,
         'hFF03, 'hFF04, 'hFF07, 'hFF08, 'hFF0F, 'hFF10, 'hFF3F, 'hFF40,
         'hFF4B, 'hFF4C, 'hFF50, 'hFF68, 'hFF6B, 'hFF70, 'hFF7F, 'hFF80,
         'hFFFE, 'hFFFF};
      model_reset();
      do_reset();
      // reset state and region boundaries (R2, R4-R12)
      foreach (edges[i]) cycle(edges[i], 1, 0, 0);
      // writes into the overlay range go to the cartridge (R2)
      cycle('h0040, 0, 1, 'h55);
      // bank register: zero acts as one, top bank, upper bits dropped (R7, R5, R6)
      cycle('hFF70, 0, 1, 'h00); cycle('hD123, 1, 0, 0); cycle('hF123, 1, 0, 0);
      cycle('hFF70, 0, 1, 'h05); cycle('hD123, 1, 0, 0); cycle('hFDFF, 1, 0, 0);
      cycle('hFF70, 0, 1, 'hFF); cycle('hFF70, 1, 0, 0); cycle('hDFFF, 1, 0, 0);
      cycle('hE456, 1, 0, 0);
      // fast RAM and interrupt enable (R11, R12)
      cycle('hFF80, 0, 1, 'h12); cycle('hFFFE, 0, 1, 'h34); cycle('hFFC0, 0, 1, 'h56);
      cycle('hFF80, 1, 0, 0); cycle('hFFFE, 1, 0, 0); cycle('hFFC0, 1, 0, 0);
      cycle('hFFFF, 0, 1, 'h1F); cycle('hFFFF, 1, 0, 0);
      // zero-read areas ignore writes (R10, R8)
      cycle('hFF20, 0, 1, 'hEE); cycle('hFF20, 1, 0, 0);
      cycle('hFEB0, 0, 1, 'hEE); cycle('hFEB0, 1, 0, 0);
      // serial latch and character pulse (R13)
      cycle('hFF01, 0, 1, 'h48); cycle('hFF02, 0, 1, 'h81); cycle('hFF02, 1, 0, 0);
      cycle('hFF01, 0, 1, 'h69); cycle('h1000, 1, 0, 0); cycle('hFF02, 0, 1, 0);
      cycle('hFF02, 0, 1, 0); cycle('h0000, 0, 0, 0);
      // overlay switch-off (R3)
      cycle('hFF50, 0, 1, 'h00); cycle('h0050, 1, 0, 0);
      cycle('hFF50, 0, 1, 'h01); cycle('h0050, 1, 0, 0);
      cycle('hFF50, 0, 1, 'h00); cycle('h00FF, 1, 0, 0);
      // reset brings the overlay back (R2)
      do_reset();
      cycle('h0050, 1, 0, 0); cycle('hFF70, 1, 0, 0); cycle('hFFC0, 1, 0, 0);
      // random run biased to the top page and work RAM
      for (int n = 0; n < 4000; n++) begin
         int a, k;
         bit w;
         k = $urandom_range(0, 3);
         a = $urandom_range(0, 'hFFFF);
         if (k == 0) a = 'hFF00 | (a & 'hFF);
         else if (k == 1) a = 'hC000 + (a % 'h3E00);
         w = ($urandom_range(0, 2) == 0);
         if (w && a == 'hFF50 && $urandom_range(0, 3) != 0) w = 0;
         cycle(a, !w, w, $urandom_range(0, 255));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule